// File: doc/BRIEF.md
# Control Register Port over a Two-Wire Serial Bus

This block is a bus slave for a two-wire serial control bus (I2C) that gives a bus master write and read access to four 8-bit control registers. The register contents leave the block as plain ports. They set the audio data format, the power-down state, the volume and the test controls of the surrounding chip. The block samples the bus clock and data lines with the system clock. It answers only at its fixed 7-bit device address 0x31, and it pulls the data line low through an output enable. It never drives the line high.

A write is three bytes. The first is the device address with the R/W bit low, the second is a register pointer and the third is the data. The slave acknowledges each of the three bytes. A read starts with the device address and the R/W bit high. It returns the register that the last accepted pointer selected, MSB first, and the slave lets go of the line when the master answers with NACK. The active-low reset returns every register to its default value.

Top module: `ctl_i2c_slave`

## Requirements
- R1: After reset the register outputs are fmt_ctl=0x00, pwr_ctl=0x00, vol_ctl=0x80 and tst_ctl=0x00, and sda_oe is 0.
- R2: A START, then the byte {0x31, R/W=0}, a pointer 0..3 and a data byte writes the data byte to the register that the pointer selects (0 fmt_ctl, 1 pwr_ctl, 2 vol_ctl, 3 tst_ctl). The slave pulls SDA low during the ninth clock of each of the three bytes.
- R3: The slave does not acknowledge an address byte whose upper seven bits differ from 0x31. It then acknowledges no further byte of that transaction and changes no register.
- R4: The slave does not acknowledge a pointer byte above 3. The data byte that follows gets no acknowledge and changes no register.
- R5: A START followed by {0x31, R/W=1} is acknowledged, and the slave then shifts out the register that the last acknowledged pointer selected, MSB first. When the master sends ACK the same register is sent again. When the master sends NACK, SDA is released and stays released until the next START.
- R6: A START at any point, including a repeated START inside a transaction, abandons the current transaction and begins a new address byte.
- R7: A byte sent after the data byte of a write is not acknowledged and changes no register. A STOP returns the slave to idle.
- R8: SDA is open drain. sda_oe is 1 only during an acknowledge clock or while a read bit of value 0 is driven, and it is 0 while the slave is idle or ignoring the bus.
- R9: Taking rst_n low during a transaction returns all registers to their defaults, and the slave then waits for a new START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| fmt_ctl | output | 8 | Register 0: format controls |
| pwr_ctl | output | 8 | Register 1: power-down controls |
| vol_ctl | output | 8 | Register 2: volume |
| tst_ctl | output | 8 | Register 3: test controls |

## Verification
The hardest situations to reach from the ports are a START that arrives in the middle of a transaction and a reset that lands halfway through a data byte. In both, the slave must drop partial state without committing a write. The bench reaches them with directed sequences: a repeated START after an accepted pointer, a repeated-START read after a pointer write, and a reset pulse four bits into a data byte. Around these it runs seeded random writes and reads with mismatched addresses, out-of-range pointers and surplus data bytes. Every result is compared against a register model kept in the bench.

// File: rtl/ctl_i2c_pkg.sv
package ctl_i2c_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK_ADDR,
      ST_PTR,
      ST_ACK_PTR,
      ST_DATA,
      ST_ACK_DATA,
      ST_RD,
      ST_RD_ACK,
      ST_IGNORE
   } bus_state_e;
endpackage

// File: rtl/ctl_i2c_sync.sv
module ctl_i2c_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   initial assert (STAGES >= 1) else $error("STAGES must be at least 1");

   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic scl_d, sda_d;
   logic scl_s;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe <= '1;
               sda_pipe <= '1;
            end else begin
               scl_pipe <= scl_i;
               sda_pipe <= sda_i;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe <= '1;
               sda_pipe <= '1;
            end else begin
               scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
               sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            end
         end
      end
   endgenerate

   assign scl_s = scl_pipe[STAGES-1];
   assign sda_s = sda_pipe[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/ctl_i2c_regbank.sv
module ctl_i2c_regbank #(
   parameter int NUM_REGS = 4,
   parameter int DATA_W   = 8,
   parameter logic [NUM_REGS*DATA_W-1:0] RESET_VALS = '0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [7:0]                 wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [7:0]                 rd_addr,
   output logic [DATA_W-1:0]          rd_data,
   output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
   localparam logic [7:0] NREG_B = 8'(NUM_REGS);

   initial assert (NUM_REGS >= 1 && NUM_REGS <= 256) else $error("NUM_REGS out of range");

   logic [DATA_W-1:0] regs [NUM_REGS];

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               regs[g] <= RESET_VALS[g*DATA_W +: DATA_W];
            else if (wr_en && wr_addr == 8'(g))
               regs[g] <= wr_data;
         end
         assign regs_flat[g*DATA_W +: DATA_W] = regs[g];
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_REGS; i++)
         if (rd_addr == 8'(i)) rd_data = regs[i];
   end

   // R4: the protocol engine never asks for a write outside the map
   assert_wr_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> wr_addr < NREG_B);
endmodule

// File: rtl/ctl_i2c_fsm.sv
module ctl_i2c_fsm
   import ctl_i2c_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h31,
   parameter int         NUM_REGS = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sda_s,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_det,
   input  logic       stop_det,
   input  logic [7:0] rd_data,
   output logic       sda_oe,
   output logic       wr_en,
   output logic [7:0] wr_data,
   output logic [7:0] ptr
);
   localparam logic [7:0] NREG_B = 8'(NUM_REGS);

   bus_state_e state;
   logic [6:0] sh;
   logic [6:0] rd_sh;
   logic [2:0] cnt;
   logic       full, ok, rw;
   logic [7:0] byte_in;
   logic       byte_ok;

   assign byte_in = {sh, sda_s};

   always_comb begin
      case (state)
         ST_ADDR: byte_ok = (byte_in[7:1] == DEV_ADDR);
         ST_PTR:  byte_ok = (byte_in < NREG_B);
         ST_DATA: byte_ok = 1'b1;
         default: byte_ok = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         sh      <= '0;
         rd_sh   <= '0;
         cnt     <= '0;
         full    <= 1'b0;
         ok      <= 1'b0;
         rw      <= 1'b0;
         sda_oe  <= 1'b0;
         wr_en   <= 1'b0;
         wr_data <= '0;
         ptr     <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            full   <= 1'b0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            full   <= 1'b0;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_PTR, ST_DATA: begin
                  if (scl_rise && !full) begin
                     sh  <= byte_in[6:0];
                     cnt <= cnt + 3'd1;
                     if (cnt == 3'd7) begin
                        full <= 1'b1;
                        ok   <= byte_ok;
                        if (state == ST_ADDR) rw <= byte_in[0];
                        if (state == ST_PTR && byte_ok) ptr <= byte_in;
                        if (state == ST_DATA) begin
                           wr_en   <= 1'b1;
                           wr_data <= byte_in;
                        end
                     end
                  end else if (scl_fall && full) begin
                     full <= 1'b0;
                     if (ok) begin
                        sda_oe <= 1'b1;
                        case (state)
                           ST_ADDR: state <= ST_ACK_ADDR;
                           ST_PTR:  state <= ST_ACK_PTR;
                           default: state <= ST_ACK_DATA;
                        endcase
                     end else begin
                        state <= ST_IGNORE;
                     end
                  end
               end
               ST_ACK_ADDR: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (rw) begin
                        state  <= ST_RD;
                        rd_sh  <= rd_data[6:0];
                        sda_oe <= ~rd_data[7];
                     end else begin
                        state  <= ST_PTR;
                        sda_oe <= 1'b0;
                     end
                  end
               end
               ST_ACK_PTR: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     state  <= ST_DATA;
                  end
               end
               ST_ACK_DATA: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     state  <= ST_IGNORE;
                  end
               end
               ST_RD: begin
                  if (scl_fall) begin
                     if (cnt == 3'd7) begin
                        sda_oe <= 1'b0;
                        state  <= ST_RD_ACK;
                        cnt    <= '0;
                     end else begin
                        sda_oe <= ~rd_sh[6];
                        rd_sh  <= {rd_sh[5:0], 1'b0};
                        cnt    <= cnt + 3'd1;
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise && sda_s) begin
                     state <= ST_IGNORE;
                  end else if (scl_fall) begin
                     state  <= ST_RD;
                     rd_sh  <= rd_data[6:0];
                     sda_oe <= ~rd_data[7];
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R8: line released whenever the slave is idle or ignoring the bus
   assert_release_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE || state == ST_IGNORE) |-> !sda_oe);

   // R8: the line is pulled only in acknowledge or read phases
   assert_pull_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe |-> (state == ST_ACK_ADDR || state == ST_ACK_PTR ||
                  state == ST_ACK_DATA || state == ST_RD));

   // R6: a START always restarts address reception with the line released
   assert_start_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state == ST_ADDR && !sda_oe));

   // R7: a STOP returns the engine to idle
   assert_stop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_det && !start_det) |=> state == ST_IDLE);

   // R2: register writes come only from the data byte of a write
   assert_write_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (state == ST_DATA && full));
endmodule

// File: rtl/ctl_i2c_slave.sv
module ctl_i2c_slave #(
   parameter logic [6:0] DEV_ADDR    = 7'h31,
   parameter int         SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   output logic [7:0] fmt_ctl,
   output logic [7:0] pwr_ctl,
   output logic [7:0] vol_ctl,
   output logic [7:0] tst_ctl
);
   localparam int NUM_REGS = 4;
   localparam int DATA_W   = ctl_i2c_pkg::BYTE_W;
   localparam logic [NUM_REGS*DATA_W-1:0] RESET_VALS = {8'h00, 8'h80, 8'h00, 8'h00};

   logic sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic wr_en;
   logic [7:0] wr_data, ptr, rd_data;
   logic [NUM_REGS*DATA_W-1:0] regs_flat;

   ctl_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   ctl_i2c_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
      .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en),
      .wr_data(wr_data), .ptr(ptr)
   );

   ctl_i2c_regbank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .RESET_VALS(RESET_VALS)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr),
      .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data),
      .regs_flat(regs_flat)
   );

   assign fmt_ctl = regs_flat[7:0];
   assign pwr_ctl = regs_flat[15:8];
   assign vol_ctl = regs_flat[23:16];
   assign tst_ctl = regs_flat[31:24];
endmodule

// File: tb/ctl_i2c_slave_tb.sv
module ctl_i2c_slave_tb;
   localparam int Q = 8;
   localparam logic [6:0] DEV = 7'h31;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   logic sda_line;
   logic [7:0] fmt_ctl, pwr_ctl, vol_ctl, tst_ctl;

   int checks = 0;
   int failures = 0;
   logic [7:0] exp_r [4];
   logic [7:0] mptr;
   bit done = 0;

   always #5 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   ctl_i2c_slave u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .sda_oe(sda_oe), .fmt_ctl(fmt_ctl), .pwr_ctl(pwr_ctl),
      .vol_ctl(vol_ctl), .tst_ctl(tst_ctl)
   );

   function automatic bit addr_hits(input logic [6:0] a);
      return a == DEV;
   endfunction

   function automatic bit ptr_valid(input logic [7:0] p);
      return p < 8'd4;
   endfunction

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
      end
   endtask

   task automatic chk_regs(input string req);
      chk(req, {24'h0, fmt_ctl}, {24'h0, exp_r[0]});
      chk(req, {24'h0, pwr_ctl}, {24'h0, exp_r[1]});
      chk(req, {24'h0, vol_ctl}, {24'h0, exp_r[2]});
      chk(req, {24'h0, tst_ctl}, {24'h0, exp_r[3]});
   endtask

   task automatic set_defaults();
      exp_r[0] = 8'h00; exp_r[1] = 8'h00; exp_r[2] = 8'h80; exp_r[3] = 8'h00;
      mptr = 8'h00;
   endtask

   task automatic clk_bit(input logic b, output logic s);
      sda_m = b; wq(Q);
      scl = 1'b1; wq(Q);
      s = sda_line; wq(Q);
      scl = 1'b0; wq(Q);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq(Q);
      scl = 1'b1; wq(Q);
      sda_m = 1'b0; wq(Q);
      scl = 1'b0; wq(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(Q);
      scl = 1'b1; wq(Q);
      sda_m = 1'b1; wq(2*Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
      clk_bit(1'b1, s);
      acked = ~s;
   endtask

   task automatic read_byte(input logic master_ack, output logic [7:0] b);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, s);
         b[i] = s;
      end
      clk_bit(~master_ack, s);
   endtask

   task automatic do_write(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d, input bit extra);
      logic ack;
      bit hit, pv;
      hit = addr_hits(a);
      pv = hit && ptr_valid(p);
      bus_start();
      send_byte({a, 1'b0}, ack);
      chk(hit ? "R2 address ack" : "R3 address nack", {31'h0, ack}, {31'h0, hit});
      send_byte(p, ack);
      chk(hit ? "R4 pointer ack" : "R3 pointer ignored", {31'h0, ack}, {31'h0, pv});
      if (pv) mptr = p;
      send_byte(d, ack);
      chk("R2 data ack", {31'h0, ack}, {31'h0, pv});
      if (pv) exp_r[p[1:0]] = d;
      if (extra) begin
         send_byte(~d, ack);
         chk("R7 surplus byte nack", {31'h0, ack}, 32'h0);
      end
      bus_stop();
      chk_regs("R2 registers after write");
   endtask

   task automatic do_read(input int reps);
      logic ack;
      logic [7:0] b;
      bus_start();
      send_byte({DEV, 1'b1}, ack);
      chk("R5 read address ack", {31'h0, ack}, 32'h1);
      for (int i = 0; i < reps; i++) begin
         read_byte(i != reps - 1, b);
         chk("R5 read data", {24'h0, b}, {24'h0, exp_r[mptr[1:0]]});
      end
      wq(2);
      chk("R5 released after NACK", {31'h0, sda_oe}, 32'h0);
      bus_stop();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic ack;
      logic [7:0] b;
      void'($urandom(32'd1234));
      set_defaults();
      wq(5);
      rst_n = 1'b1;
      wq(3);
      // R1 reset state
      chk_regs("R1 defaults");
      chk("R1 sda_oe idle", {31'h0, sda_oe}, 32'h0);

      // R2 directed writes to every register
      do_write(DEV, 8'd0, 8'h3C, 0);
      do_write(DEV, 8'd1, 8'hE1, 0);
      do_write(DEV, 8'd2, 8'h5A, 0);
      do_write(DEV, 8'd3, 8'hA5, 0);
      // R3 wrong address, R4 pointer 4, R7 surplus byte
      do_write(7'h30, 8'd2, 8'h11, 0);
      do_write(DEV, 8'd4, 8'h22, 0);
      do_write(DEV, 8'd1, 8'h77, 1);
      // R5 read of last pointer with ACK then NACK
      do_read(2);

      // R6 repeated START after accepted pointer
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'd1, ack);
      chk("R6 first pointer ack", {31'h0, ack}, 32'h1);
      mptr = 8'd1;
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      chk("R6 address after restart", {31'h0, ack}, 32'h1);
      send_byte(8'd2, ack);
      mptr = 8'd2;
      send_byte(8'hC3, ack);
      exp_r[2] = 8'hC3;
      bus_stop();
      chk_regs("R6 only second transaction wrote");

      // R5 pointer write, repeated START, read
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'd3, ack);
      mptr = 8'd3;
      bus_start();
      send_byte({DEV, 1'b1}, ack);
      chk("R5 restart read ack", {31'h0, ack}, 32'h1);
      read_byte(1'b1, b);
      chk("R5 restart read first", {24'h0, b}, {24'h0, exp_r[3]});
      read_byte(1'b0, b);
      chk("R5 restart read repeat", {24'h0, b}, {24'h0, exp_r[3]});
      wq(2);
      chk("R8 released after NACK", {31'h0, sda_oe}, 32'h0);
      bus_stop();

      // R9 reset in the middle of a data byte
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'd0, ack);
      for (int i = 0; i < 4; i++) clk_bit(1'b1, ack);
      rst_n = 1'b0;
      wq(3);
      rst_n = 1'b1;
      set_defaults();
      wq(2);
      chk_regs("R9 defaults after mid-transfer reset");
      chk("R9 line released", {31'h0, sda_oe}, 32'h0);
      bus_stop();
      do_write(DEV, 8'd0, 8'h9E, 0);

      // random mix
      for (int it = 0; it < 36; it++) begin
         logic [6:0] a;
         logic [7:0] p, d;
         bit extra;
         a = ($urandom % 4 == 0) ? 7'($urandom) : DEV;
         p = 8'($urandom % 6);
         d = 8'($urandom);
         extra = ($urandom % 5 == 0);
         do_write(a, p, d, extra);
         if (it % 3 == 2) do_read(1 + ($urandom % 2));
      end

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule